// File: doc/BRIEF.md
# Processor Control Register Update Unit

This unit keeps the paging and mode control state of a processor core: the three main control registers (mode control, translation root and extension control), the long-mode enable and active bits, and the mask that gates physical address bit 20. Writes from the core go through it. Each write is checked against the old value, and when a bit that address translation depends on changes, the unit tells the translation cache to drop its contents. A full drop removes every entry, global ones included. A local drop keeps global entries.

The unit also produces the hidden mode flags that the rest of the core reads instead of decoding the registers again: protected mode, forced segment-base addition, the three floating-point trap controls, the extended-save enable, long mode active and 64-bit code. Long-mode entry and exit are handled by a small state machine. Its states are LM_LEGACY (long mode inactive), LM_COMPAT (long mode active, 32-bit code) and LM_WIDE (long mode active, 64-bit code). These transitions are defined:

- LM_LEGACY to LM_COMPAT on a valid entry.
- LM_COMPAT and LM_WIDE to LM_LEGACY on exit.
- LM_COMPAT to LM_WIDE on a code-width load of 1.
- LM_WIDE to LM_COMPAT on a code-width load of 0.

Exceptions are never raised. An entry attempt that is not legal is discarded without any effect.

Top module: `crx_update_unit`

## Requirements
- R1: After reset, the mode register reads 0x60000010. The root register, the extension register, the long-mode enable and all long-mode flags are 0. The address mask is 0xFFFFFFFF, and no flush or truncate pulse is active.
- R2: A mode register write is stored with bit 4 forced to 1. The protected flag equals stored bit 0, and the three floating-point trap flags (mp, em, ts) equal stored bits 1, 2 and 3.
- R3: A mode register write that is accepted raises flush_all when bit 31 (paging), bit 16 (write protect) or bit 0 (protected) differs from the old value. A write that changes none of these bits raises no flush.
- R4: A mode register write that takes bit 31 from 0 to 1 while the long-mode enable is 1 enters long mode when extension bit 5 (PAE) is 1. When bit 5 is 0, the write is dropped: the register, the flags and the flush outputs stay unchanged.
- R5: An accepted mode register write that takes bit 31 from 1 to 0 while long mode is active leaves long mode. It clears the long-mode and 64-bit code flags and pulses ip_trunc for one cycle.
- R6: A code-width load sets cs64_flag to code64_val only while long mode is active. When long mode is not active, the load is ignored. An exit in the same cycle wins over the load.
- R7: A root register write is stored. It pulses flush_local only when the old mode register bit 31 is 1.
- R8: An extension register write raises flush_all when bit 4 (large pages), bit 5 (PAE) or bit 7 (global pages) changes. Bit 9 is stored as 0 when sse_ok is 0, and osfxsr_flag follows stored bit 9.
- R9: A change on a20_gate raises flush_all and sets the mask to 0xFFEFFFFF with bit 20 equal to the new gate value. A gate value that does not change has no effect.
- R10: Flush pulses are high for exactly the one cycle after their cause. When a local flush and a full flush fall in the same cycle, only flush_all is raised.
- R11: addseg_flag is 1 whenever the protected bit is 0, and a mode register write with bit 0 clear forces it to 1. A neighbour write through seg_base_wr takes effect only when the protected bit after that cycle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cr0_wr_en | input | 1 | Mode register write strobe |
| cr0_wr_data | input | 32 | Mode register write value |
| cr3_wr_en | input | 1 | Root register write strobe |
| cr3_wr_data | input | 32 | Root register write value |
| cr4_wr_en | input | 1 | Extension register write strobe |
| cr4_wr_data | input | 32 | Extension register write value |
| lme_wr_en | input | 1 | Long-mode enable write strobe |
| lme_wr_val | input | 1 | Long-mode enable value |
| code64_ld | input | 1 | Code-width load strobe |
| code64_val | input | 1 | 1 for 64-bit code, 0 for 32-bit code |
| seg_base_wr | input | 1 | Neighbour write of the segment-base flag |
| seg_base_val | input | 1 | Value for the segment-base flag |
| a20_gate | input | 1 | Address bit 20 gate level |
| sse_ok | input | 1 | Strap: extended-save instructions supported |
| cr0_q | output | 32 | Mode register |
| cr3_q | output | 32 | Root register |
| cr4_q | output | 32 | Extension register |
| efer_lme | output | 1 | Long-mode enable |
| lma_flag | output | 1 | Long mode active |
| cs64_flag | output | 1 | 64-bit code |
| pe_flag | output | 1 | Protected mode |
| addseg_flag | output | 1 | Add segment base |
| mp_flag | output | 1 | Monitor coprocessor |
| em_flag | output | 1 | Emulate coprocessor |
| ts_flag | output | 1 | Task switched |
| osfxsr_flag | output | 1 | Extended save enabled |
| flush_all | output | 1 | Full translation flush pulse |
| flush_local | output | 1 | Non-global translation flush pulse |
| ip_trunc | output | 1 | Instruction pointer truncate pulse |
| a20_mask | output | 32 | Physical address mask |

## Verification
The mode register is tried with several patterns. Writes of an identical value show that a full flush is raised only when a translation bit changes. Writes that flip only the trap bits check the flag mapping without a flush. A write-protect toggle alone checks the middle bit of the compared set. The paging bit is driven through entry with PAE set, entry with PAE clear (dropped), exit from both active states, and code-width loads in every state, including a load in the same cycle as an exit. The root register is written with paging off and with paging on. The extension register is written with sse_ok at 0 and at 1, and in the same cycle as a root register write, so that the local flush is seen to be suppressed. The gate is toggled twice and held steady once.

// File: rtl/crx_pkg.sv
package crx_pkg;
    localparam int CR0_PE  = 0;
    localparam int CR0_MP  = 1;
    localparam int CR0_EM  = 2;
    localparam int CR0_TS  = 3;
    localparam int CR0_ET  = 4;
    localparam int CR0_WP  = 16;
    localparam int CR0_PG  = 31;
    localparam int CR4_PSE = 4;
    localparam int CR4_PAE = 5;
    localparam int CR4_PGE = 7;
    localparam int CR4_OSX = 9;

    typedef enum logic [1:0] {
        LM_LEGACY = 2'd0,
        LM_COMPAT = 2'd1,
        LM_WIDE   = 2'd2
    } lm_state_e;
endpackage

// File: rtl/crx_mode_fsm.sv
module crx_mode_fsm
    import crx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_req,
    input  logic exit_req,
    input  logic code64_ld,
    input  logic code64_val,
    output logic lma,
    output logic cs64
);
    lm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LM_LEGACY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LM_LEGACY: if (enter_req) state_d = LM_COMPAT;
            LM_COMPAT: begin
                if (exit_req)                    state_d = LM_LEGACY;
                else if (code64_ld && code64_val) state_d = LM_WIDE;
            end
            LM_WIDE: begin
                if (exit_req)                     state_d = LM_LEGACY;
                else if (code64_ld && !code64_val) state_d = LM_COMPAT;
            end
            default: state_d = LM_LEGACY;
        endcase
    end

    always_comb begin
        lma  = 1'b0;
        cs64 = 1'b0;
        unique case (state_q)
            LM_LEGACY: ;
            LM_COMPAT: lma = 1'b1;
            LM_WIDE: begin
                lma  = 1'b1;
                cs64 = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/crx_cr0_ctl.sv
module crx_cr0_ctl
    import crx_pkg::*;
#(
    parameter int          DW        = 32,
    parameter logic [31:0] RESET_VAL = 32'h6000_0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          lme,
    input  logic          pae,
    input  logic          lma,
    input  logic          seg_wr,
    input  logic          seg_val,
    output logic [DW-1:0] cr0_q,
    output logic          addseg_q,
    output logic          enter_req,
    output logic          exit_req,
    output logic          flush_req
);
    localparam logic [DW-1:0] XLATE_BITS =
        (DW'(1) << CR0_PG) | (DW'(1) << CR0_WP) | (DW'(1) << CR0_PE);
    localparam logic [DW-1:0] ET_BIT = DW'(1) << CR0_ET;

    logic enter_try, dropped, take, pe_next;

    always_comb begin
        enter_try = wr_en && !cr0_q[CR0_PG] && wr_data[CR0_PG] && lme;
        dropped   = enter_try && !pae;
        take      = wr_en && !dropped;
        enter_req = enter_try && pae;
        exit_req  = take && cr0_q[CR0_PG] && !wr_data[CR0_PG] && lma;
        flush_req = take && (((wr_data ^ cr0_q) & XLATE_BITS) != '0);
        pe_next   = take ? wr_data[CR0_PE] : cr0_q[CR0_PE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr0_q    <= DW'(RESET_VAL);
            addseg_q <= 1'b1;
        end else begin
            if (take) cr0_q <= wr_data | ET_BIT;
            if (!pe_next)    addseg_q <= 1'b1;
            else if (seg_wr) addseg_q <= seg_val;
        end
    end
endmodule

// File: rtl/crx_cr4_ctl.sv
module crx_cr4_ctl
    import crx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          sse_ok,
    output logic [DW-1:0] cr4_q,
    output logic          flush_req
);
    localparam logic [DW-1:0] XLATE_BITS =
        (DW'(1) << CR4_PGE) | (DW'(1) << CR4_PAE) | (DW'(1) << CR4_PSE);
    localparam logic [DW-1:0] OSX_BIT = DW'(1) << CR4_OSX;

    logic [DW-1:0] cleaned;

    always_comb begin
        cleaned   = sse_ok ? wr_data : (wr_data & ~OSX_BIT);
        flush_req = wr_en && (((cleaned ^ cr4_q) & XLATE_BITS) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cr4_q <= '0;
        else if (wr_en) cr4_q <= cleaned;
    end
endmodule

// File: rtl/crx_a20_gate.sv
module crx_a20_gate #(
    parameter int DW      = 32,
    parameter int GATE_BIT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_in,
    output logic [DW-1:0] mask_q,
    output logic          flush_req
);
    localparam logic [DW-1:0] HOLE = ~(DW'(1) << GATE_BIT);

    logic gate_q;

    assign flush_req = gate_in != gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b1;
            mask_q <= '1;
        end else if (flush_req) begin
            gate_q <= gate_in;
            mask_q <= HOLE | (DW'(gate_in) << GATE_BIT);
        end
    end
endmodule

// File: rtl/crx_update_unit.sv
module crx_update_unit
    import crx_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          GATE_BIT  = 20,
    parameter logic [31:0] CR0_RESET = 32'h6000_0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cr0_wr_en,
    input  logic [DW-1:0] cr0_wr_data,
    input  logic          cr3_wr_en,
    input  logic [DW-1:0] cr3_wr_data,
    input  logic          cr4_wr_en,
    input  logic [DW-1:0] cr4_wr_data,
    input  logic          lme_wr_en,
    input  logic          lme_wr_val,
    input  logic          code64_ld,
    input  logic          code64_val,
    input  logic          seg_base_wr,
    input  logic          seg_base_val,
    input  logic          a20_gate,
    input  logic          sse_ok,
    output logic [DW-1:0] cr0_q,
    output logic [DW-1:0] cr3_q,
    output logic [DW-1:0] cr4_q,
    output logic          efer_lme,
    output logic          lma_flag,
    output logic          cs64_flag,
    output logic          pe_flag,
    output logic          addseg_flag,
    output logic          mp_flag,
    output logic          em_flag,
    output logic          ts_flag,
    output logic          osfxsr_flag,
    output logic          flush_all,
    output logic          flush_local,
    output logic          ip_trunc,
    output logic [DW-1:0] a20_mask
);
    logic enter_req, exit_req, cr0_flush, cr4_flush, a20_flush;
    logic all_d, local_d;

    crx_cr0_ctl #(.DW(DW), .RESET_VAL(CR0_RESET)) u_cr0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cr0_wr_en),
        .wr_data   (cr0_wr_data),
        .lme       (efer_lme),
        .pae       (cr4_q[CR4_PAE]),
        .lma       (lma_flag),
        .seg_wr    (seg_base_wr),
        .seg_val   (seg_base_val),
        .cr0_q     (cr0_q),
        .addseg_q  (addseg_flag),
        .enter_req (enter_req),
        .exit_req  (exit_req),
        .flush_req (cr0_flush)
    );

    crx_cr4_ctl #(.DW(DW)) u_cr4 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cr4_wr_en),
        .wr_data   (cr4_wr_data),
        .sse_ok    (sse_ok),
        .cr4_q     (cr4_q),
        .flush_req (cr4_flush)
    );

    crx_a20_gate #(.DW(DW), .GATE_BIT(GATE_BIT)) u_a20 (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_in   (a20_gate),
        .mask_q    (a20_mask),
        .flush_req (a20_flush)
    );

    crx_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .code64_ld  (code64_ld),
        .code64_val (code64_val),
        .lma        (lma_flag),
        .cs64       (cs64_flag)
    );

    always_comb begin
        all_d   = cr0_flush || cr4_flush || a20_flush;
        local_d = cr3_wr_en && cr0_q[CR0_PG] && !all_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr3_q       <= '0;
            efer_lme    <= 1'b0;
            flush_all   <= 1'b0;
            flush_local <= 1'b0;
            ip_trunc    <= 1'b0;
        end else begin
            if (cr3_wr_en) cr3_q    <= cr3_wr_data;
            if (lme_wr_en) efer_lme <= lme_wr_val;
            flush_all   <= all_d;
            flush_local <= local_d;
            ip_trunc    <= exit_req;
        end
    end

    assign pe_flag     = cr0_q[CR0_PE];
    assign mp_flag     = cr0_q[CR0_MP];
    assign em_flag     = cr0_q[CR0_EM];
    assign ts_flag     = cr0_q[CR0_TS];
    assign osfxsr_flag = cr4_q[CR4_OSX];
endmodule

// File: rtl/crx_update_unit_chk.sv
module crx_update_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cr0_wr_en,
    input logic [31:0] cr0_wr_data,
    input logic        cr3_wr_en,
    input logic        cr4_wr_en,
    input logic        sse_ok,
    input logic        a20_gate,
    input logic [31:0] cr0_q,
    input logic [31:0] cr4_q,
    input logic        efer_lme,
    input logic        lma_flag,
    input logic        cs64_flag,
    input logic        pe_flag,
    input logic        addseg_flag,
    input logic        flush_all,
    input logic        flush_local,
    input logic        ip_trunc,
    input logic [31:0] a20_mask
);
    assert_et_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_q[4]);

    assert_drop_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0_wr_en && !cr0_q[31] && cr0_wr_data[31] && efer_lme && !cr4_q[5])
        |=> ($stable(cr0_q) && !lma_flag && !flush_all));

    assert_exit_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ip_trunc |-> (!lma_flag && !cs64_flag && !cr0_q[31]));

    assert_wide_in_lm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs64_flag |-> lma_flag);

    assert_local_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_local |-> ($past(cr3_wr_en) && $past(cr0_q[31])));

    assert_osx_strap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cr4_wr_en && !sse_ok) |=> !cr4_q[9]);

    assert_mask_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (a20_mask[20] == $past(a20_gate)));

    assert_flush_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_all && flush_local));

    assert_addseg_real_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_flag |-> addseg_flag);
endmodule

bind crx_update_unit crx_update_unit_chk u_chk (.*);

// File: tb/crx_update_unit_tb.sv
module crx_update_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr0_wr_en = 0, cr3_wr_en = 0, cr4_wr_en = 0, lme_wr_en = 0;
    logic [31:0] cr0_wr_data = 0, cr3_wr_data = 0, cr4_wr_data = 0;
    logic        lme_wr_val = 0, code64_ld = 0, code64_val = 0;
    logic        seg_base_wr = 0, seg_base_val = 0, a20_gate = 1, sse_ok = 0;
    logic [31:0] cr0_q, cr3_q, cr4_q, a20_mask;
    logic        efer_lme, lma_flag, cs64_flag, pe_flag, addseg_flag;
    logic        mp_flag, em_flag, ts_flag, osfxsr_flag;
    logic        flush_all, flush_local, ip_trunc;

    int checks = 0, fails = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crx_update_unit u_dut (.*);

    // behavioural reference
    logic [31:0] m_cr0, m_cr3, m_cr4, m_mask;
    bit m_lme, m_lma, m_c64, m_seg, m_gate, m_all, m_loc, m_tr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cr0 = 32'h6000_0010; m_cr3 = 0; m_cr4 = 0; m_mask = 32'hFFFF_FFFF;
            m_lme = 0; m_lma = 0; m_c64 = 0; m_seg = 1; m_gate = 1;
            m_all = 0; m_loc = 0; m_tr = 0;
        end else begin
            bit g, enter, leave, pe_n;
            logic [31:0] n_cr0, c4;
            g = 0; enter = 0; leave = 0; n_cr0 = m_cr0;
            if (cr0_wr_en) begin
                if (!m_cr0[31] && cr0_wr_data[31] && m_lme && !m_cr4[5]) begin
                    // dropped entry attempt
                end else begin
                    if (((cr0_wr_data ^ m_cr0) & 32'h8001_0001) != 0) g = 1;
                    enter = !m_cr0[31] && cr0_wr_data[31] && m_lme;
                    leave = m_cr0[31] && !cr0_wr_data[31] && m_lma;
                    n_cr0 = cr0_wr_data | 32'h10;
                end
            end
            if (cr4_wr_en) begin
                c4 = sse_ok ? cr4_wr_data : (cr4_wr_data & ~32'h200);
                if (((c4 ^ m_cr4) & 32'hB0) != 0) g = 1;
                m_cr4 = c4;
            end
            if (a20_gate != m_gate) begin
                g = 1;
                m_gate = a20_gate;
                m_mask = 32'hFFEF_FFFF | (32'(a20_gate) << 20);
            end
            m_loc = cr3_wr_en && m_cr0[31] && !g;
            m_all = g;
            m_tr  = leave;
            if (cr3_wr_en) m_cr3 = cr3_wr_data;
            if (leave) begin m_lma = 0; m_c64 = 0; end
            else if (enter) begin m_lma = 1; m_c64 = 0; end
            else if (code64_ld && m_lma) m_c64 = code64_val;
            if (lme_wr_en) m_lme = lme_wr_val;
            m_cr0 = n_cr0;
            pe_n = n_cr0[0];
            if (!pe_n) m_seg = 1;
            else if (seg_base_wr) m_seg = seg_base_val;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) if (cmp_on && !done) begin
        chk("R2 cr0", cr0_q, m_cr0);
        chk("R2 flags", {pe_flag, mp_flag, em_flag, ts_flag}, {m_cr0[0], m_cr0[1], m_cr0[2], m_cr0[3]});
        chk("R3 flush_all", flush_all, m_all);
        chk("R4 lma", lma_flag, m_lma);
        chk("R4 lme", efer_lme, m_lme);
        chk("R5 ip_trunc", ip_trunc, m_tr);
        chk("R6 cs64", cs64_flag, m_c64);
        chk("R7 cr3", cr3_q, m_cr3);
        chk("R7 flush_local", flush_local, m_loc);
        chk("R8 cr4", cr4_q, m_cr4);
        chk("R8 osfxsr", osfxsr_flag, m_cr4[9]);
        chk("R9 mask", a20_mask, m_mask);
        chk("R11 addseg", addseg_flag, m_seg);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic w0(logic [31:0] d);
        @(negedge clk); cr0_wr_en = 1; cr0_wr_data = d;
        @(negedge clk); cr0_wr_en = 0;
    endtask
    task automatic w3(logic [31:0] d);
        @(negedge clk); cr3_wr_en = 1; cr3_wr_data = d;
        @(negedge clk); cr3_wr_en = 0;
    endtask
    task automatic w4(logic [31:0] d);
        @(negedge clk); cr4_wr_en = 1; cr4_wr_data = d;
        @(negedge clk); cr4_wr_en = 0;
    endtask
    task automatic seg(logic v);
        @(negedge clk); seg_base_wr = 1; seg_base_val = v;
        @(negedge clk); seg_base_wr = 0;
    endtask
    task automatic c64(logic v);
        @(negedge clk); code64_ld = 1; code64_val = v;
        @(negedge clk); code64_ld = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cr0 reset", cr0_q, 32'h6000_0010);
        chk("R1 mask reset", a20_mask, 32'hFFFF_FFFF);
        chk("R1 regs reset", {cr3_q[15:0], cr4_q[15:0]}, 32'h0);
        chk("R1 pulses reset", {flush_all, flush_local, ip_trunc, lma_flag, cs64_flag, efer_lme}, 0);
        cmp_on = 1;
        w0(32'h6000_0011); idle(1);             // R3 protected bit change
        w0(32'h0000_000E); idle(1);             // R2 trap flags, R11 forced
        seg(0); w0(32'h0000_0001); seg(0); seg(1); // R11 ignored then taken
        w3(32'h0000_1000);                      // R7 paging off: no flush
        w4(32'h0000_0200); sse_ok = 1;          // R8 strap clears bit 9
        w4(32'h0000_0200); w4(32'h0000_0220);   // R8 PAE change flushes
        w0(32'h8000_0001); w3(32'h0000_2000);   // R7 local flush
        // R10 both causes in one cycle
        @(negedge clk); cr3_wr_en = 1; cr3_wr_data = 32'h3000; cr4_wr_en = 1; cr4_wr_data = 32'h230;
        @(negedge clk); cr3_wr_en = 0; cr4_wr_en = 0;
        chk("R10 only global", {flush_all, flush_local}, 2'b10);
        @(negedge clk);
        chk("R10 one cycle", flush_all, 1'b0);
        w0(32'h8000_0001); w0(32'h8001_0001);   // R3 same value, WP toggle
        w0(32'h0000_0001);
        @(negedge clk); lme_wr_en = 1; lme_wr_val = 1; @(negedge clk); lme_wr_en = 0;
        w4(32'h0000_0200);
        c64(1);                                 // R6 ignored outside long mode
        w0(32'h8000_0001); idle(1);             // R4 dropped
        w4(32'h0000_0220);
        w0(32'h8000_0001); c64(1); c64(0); c64(1); // R4 entry, R6 loads
        w0(32'h0000_0001); idle(1);             // R5 exit from wide
        w0(32'h8000_0001);
        // R6 exit wins over load
        @(negedge clk); cr0_wr_en = 1; cr0_wr_data = 32'h1; code64_ld = 1; code64_val = 1;
        @(negedge clk); cr0_wr_en = 0; code64_ld = 0;
        idle(1);
        @(negedge clk); a20_gate = 0; idle(3);  // R9 gate low
        @(negedge clk); a20_gate = 1; idle(3);  // R9 gate high
        w0(32'h6000_0000); idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule